// File: doc/BRIEF.md
# Request Acceptance Controller

This block sits in the bus controller of a small processor and decides, once per machine cycle, which pending request gets the bus and which operating state follows. It follows eight states: normal run (covering both the CPU and I/O-stop cases), wait, refresh cycle, interrupt-acknowledge cycle, DMA cycle, bus release, sleep and system stop. Each state accepts only a subset of the requests, and the rest are held off until a state that accepts them.

The inputs are the request lines: wait, on-chip refresh, two DMA channels, external bus request and three maskable interrupt lines. Two strobes give the timing: one marks the end of a machine cycle and one the end of an instruction. Two command inputs put the block into sleep or system stop. The outputs are a registered state code plus one-hot grant and acknowledge lines. Address generation for refresh and DMA and the instruction datapath are outside this block.

Top module: `req_accept_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in normal run (state code 0), with bus_ack, rfsh_gnt, dma_ack and int_ack all low from the next clock.
- R2: The state code changes only on a clock where mc_end is high. The codes are: 0 run, 1 wait, 2 refresh, 3 interrupt acknowledge, 4 DMA, 5 bus release, 6 sleep, 7 system stop.
- R3: In run at a machine-cycle end, the block moves on the highest-priority pending request in this order: bus request, refresh, DMA channel 0, DMA channel 1, interrupt, wait, stop command, sleep command. Requests that lose stay pending.
- R4: An interrupt is accepted from run only when insn_end is high at the same machine-cycle end. int_ack is then one-hot on the lowest-numbered active line (bit n for line n).
- R5: Refresh, interrupt-acknowledge and DMA cycles each last one machine cycle and then return to run. A refresh or wait request during them starts nothing.
- R6: The wait state holds while wait_req stays high at machine-cycle ends and returns to run at the first end where it is low.
- R7: Bus release raises bus_ack and holds while bus_req stays high. Wait, refresh and DMA requests are ignored during it.
- R8: When bus release ends from run with a DMA request pending, the block spends one machine cycle in run and then enters the DMA cycle.
- R9: In sleep, wait, refresh and DMA requests are ignored. An interrupt returns to run, and a bus request (taken ahead of the interrupt) enters bus release, which goes back to sleep when it ends.
- R10: System stop behaves like sleep: wait, refresh and DMA are ignored, a bus request enters bus release and returns to stop, and an interrupt returns to run.
- R11: bus_ack, rfsh_gnt, any dma_ack bit and any int_ack bit are never high together. dma_ack is one-hot on the granted channel (bit 0 for channel 0) and high only in the DMA state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_end | input | 1 | High on the last clock of a machine cycle |
| insn_end | input | 1 | High when the current instruction completes |
| wait_req | input | 1 | Wait-state request |
| rfsh_req | input | 1 | Refresh request from the on-chip refresh timer |
| dma_req | input | 2 | DMA requests, bit n for channel n |
| bus_req | input | 1 | External bus request |
| irq | input | 3 | Maskable interrupt lines |
| sleep_cmd | input | 1 | Command to enter sleep |
| stop_cmd | input | 1 | Command to enter system stop |
| state_code | output | 3 | Current state code |
| bus_ack | output | 1 | Bus released |
| rfsh_gnt | output | 1 | Refresh cycle granted |
| dma_ack | output | 2 | DMA channel granted, one-hot |
| int_ack | output | 3 | Interrupt line acknowledged, one-hot |

## Verification
The bench stresses the priority ladder by raising every request at once. A design with the order wrong would grant refresh or DMA while an external master is waiting. It checks that an interrupt arriving mid-instruction is held off; a design that ignores insn_end would acknowledge in the middle of an instruction. It also walks the return path from bus release back to sleep and the one-cycle gap before a pending DMA. A design that drops the saved low-power state would wake the processor, and one that skips the gap would start DMA straight out of bus release. Random traffic then compares every cycle against a bench model, to catch grants that change between machine-cycle ends.

// File: rtl/rac_pkg.sv
package rac_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_RFSH  = 3'd2,
    ST_IACK  = 3'd3,
    ST_DMA   = 3'd4,
    ST_BREL  = 3'd5,
    ST_SLEEP = 3'd6,
    ST_STOP  = 3'd7
  } rac_state_e;
endpackage

// File: rtl/rac_first.sv
// Lowest-index active bit finder.
module rac_first #(
  parameter int N  = 3,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/rac_next.sv
// Next-state decision taken at each machine-cycle end.
module rac_next
  import rac_pkg::*;
#(
  parameter int NDMA = 2,
  parameter int NIRQ = 3,
  localparam int DW  = (NDMA > 1) ? $clog2(NDMA) : 1,
  localparam int IW  = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  rac_state_e      state,
  input  rac_state_e      ret,
  input  logic            insn_end,
  input  logic            wait_req,
  input  logic            rfsh_req,
  input  logic [NDMA-1:0] dma_req,
  input  logic            bus_req,
  input  logic [NIRQ-1:0] irq,
  input  logic            sleep_cmd,
  input  logic            stop_cmd,
  output rac_state_e      state_n,
  output rac_state_e      ret_n,
  output logic [DW-1:0]   dma_idx,
  output logic [IW-1:0]   irq_idx
);
  logic dma_any, irq_any;

  rac_first #(.N(NDMA)) dma_pick (.req(dma_req), .any(dma_any), .idx(dma_idx));
  rac_first #(.N(NIRQ)) irq_pick (.req(irq),     .any(irq_any), .idx(irq_idx));

  always_comb begin
    state_n = state;
    ret_n   = ret;
    case (state)
      ST_RUN: begin
        if (bus_req) begin
          state_n = ST_BREL;
          ret_n   = ST_RUN;
        end
        else if (rfsh_req)             state_n = ST_RFSH;
        else if (dma_any)              state_n = ST_DMA;
        else if (insn_end && irq_any)  state_n = ST_IACK;
        else if (wait_req)             state_n = ST_WAIT;
        else if (stop_cmd)             state_n = ST_STOP;
        else if (sleep_cmd)            state_n = ST_SLEEP;
      end
      ST_WAIT:                   if (!wait_req) state_n = ST_RUN;
      ST_RFSH, ST_IACK, ST_DMA:  state_n = ST_RUN;
      ST_BREL:                   if (!bus_req) state_n = ret;
      ST_SLEEP, ST_STOP: begin
        if (bus_req) begin
          state_n = ST_BREL;
          ret_n   = state;
        end
        else if (irq_any) state_n = ST_RUN;
      end
      default: state_n = ST_RUN;
    endcase
  end
endmodule

// File: rtl/req_accept_ctrl.sv
module req_accept_ctrl
  import rac_pkg::*;
#(
  parameter int NDMA = 2,
  parameter int NIRQ = 3,
  localparam int DW  = (NDMA > 1) ? $clog2(NDMA) : 1,
  localparam int IW  = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mc_end,
  input  logic            insn_end,
  input  logic            wait_req,
  input  logic            rfsh_req,
  input  logic [NDMA-1:0] dma_req,
  input  logic            bus_req,
  input  logic [NIRQ-1:0] irq,
  input  logic            sleep_cmd,
  input  logic            stop_cmd,
  output logic [2:0]      state_code,
  output logic            bus_ack,
  output logic            rfsh_gnt,
  output logic [NDMA-1:0] dma_ack,
  output logic [NIRQ-1:0] int_ack
);
  rac_state_e    state_q, ret_q, state_n, ret_n;
  logic [DW-1:0] dma_idx;
  logic [IW-1:0] irq_idx;

  rac_next #(.NDMA(NDMA), .NIRQ(NIRQ)) next_i (
    .state(state_q), .ret(ret_q), .insn_end(insn_end), .wait_req(wait_req),
    .rfsh_req(rfsh_req), .dma_req(dma_req), .bus_req(bus_req), .irq(irq),
    .sleep_cmd(sleep_cmd), .stop_cmd(stop_cmd),
    .state_n(state_n), .ret_n(ret_n), .dma_idx(dma_idx), .irq_idx(irq_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_RUN;
      ret_q    <= ST_RUN;
      bus_ack  <= 1'b0;
      rfsh_gnt <= 1'b0;
      dma_ack  <= '0;
      int_ack  <= '0;
    end
    else if (mc_end) begin
      state_q  <= state_n;
      ret_q    <= ret_n;
      bus_ack  <= (state_n == ST_BREL);
      rfsh_gnt <= (state_n == ST_RFSH);
      dma_ack  <= (state_n == ST_DMA)  ? (NDMA'(1) << dma_idx) : '0;
      int_ack  <= (state_n == ST_IACK) ? (NIRQ'(1) << irq_idx) : '0;
    end
  end

  assign state_code = state_q;
endmodule

// File: rtl/rac_chk.sv
module rac_chk
  import rac_pkg::*;
#(
  parameter int NDMA = 2,
  parameter int NIRQ = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            mc_end,
  input logic            insn_end,
  input logic            bus_req,
  input logic [2:0]      state_code,
  input logic            bus_ack,
  input logic            rfsh_gnt,
  input logic [NDMA-1:0] dma_ack,
  input logic [NIRQ-1:0] int_ack
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (state_code == 3'd0 && !bus_ack && !rfsh_gnt && dma_ack == '0 && int_ack == '0));

  assert_boundary_only_R2: assert property (@(posedge clk) disable iff (rst)
    !mc_end |=> $stable(state_code));

  assert_irq_insn_end_R4: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'(ST_RUN) && !insn_end) |=> state_code != 3'(ST_IACK));

  assert_short_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    ((state_code == 3'(ST_RFSH) || state_code == 3'(ST_IACK) || state_code == 3'(ST_DMA)) && mc_end)
    |=> state_code == 3'(ST_RUN));

  assert_bus_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'(ST_BREL) && bus_req) |=> (state_code == 3'(ST_BREL) && bus_ack));

  assert_sleep_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'(ST_SLEEP)) |=>
    (state_code == 3'(ST_SLEEP) || state_code == 3'(ST_RUN) || state_code == 3'(ST_BREL)));

  assert_grant_excl_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_ack, rfsh_gnt, |dma_ack, |int_ack}) && $onehot0(dma_ack) && $onehot0(int_ack));
endmodule

bind req_accept_ctrl rac_chk #(.NDMA(NDMA), .NIRQ(NIRQ)) chk_i (
  .clk(clk), .rst(rst), .mc_end(mc_end), .insn_end(insn_end), .bus_req(bus_req),
  .state_code(state_code), .bus_ack(bus_ack), .rfsh_gnt(rfsh_gnt),
  .dma_ack(dma_ack), .int_ack(int_ack)
);

// File: tb/req_accept_ctrl_tb_top.sv
`timescale 1ns/1ps
module req_accept_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mc_end = 0, insn_end = 0, wait_req = 0, rfsh_req = 0, bus_req = 0;
  logic sleep_cmd = 0, stop_cmd = 0;
  logic [1:0] dma_req = '0;
  logic [2:0] irq = '0;
  logic [2:0] state_code;
  logic bus_ack, rfsh_gnt;
  logic [1:0] dma_ack;
  logic [2:0] int_ack;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  req_accept_ctrl dut_i (
    .clk(clk), .rst(rst), .mc_end(mc_end), .insn_end(insn_end), .wait_req(wait_req),
    .rfsh_req(rfsh_req), .dma_req(dma_req), .bus_req(bus_req), .irq(irq),
    .sleep_cmd(sleep_cmd), .stop_cmd(stop_cmd), .state_code(state_code),
    .bus_ack(bus_ack), .rfsh_gnt(rfsh_gnt), .dma_ack(dma_ack), .int_ack(int_ack)
  );

  // Bench model of the requirements
  int m_st = 0, m_ret = 0, m_ch = 0, m_ln = 0;
  string m_tag = "R1";

  function automatic int lowest(input logic [2:0] v);
    for (int i = 0; i < 3; i++) if (v[i]) return i;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_ret = 0; m_tag = "R1";
    end
    else if (!mc_end) m_tag = "R2";
    else begin
      case (m_st)
        0: begin
          m_tag = "R3";
          if (bus_req) begin m_st = 5; m_ret = 0; end
          else if (rfsh_req) m_st = 2;
          else if (|dma_req) begin m_st = 4; m_ch = lowest({1'b0, dma_req}); end
          else if (insn_end && |irq) begin m_st = 3; m_ln = lowest(irq); m_tag = "R4"; end
          else if (wait_req) m_st = 1;
          else if (stop_cmd) m_st = 7;
          else if (sleep_cmd) m_st = 6;
        end
        1: begin m_tag = "R6"; if (!wait_req) m_st = 0; end
        2, 3, 4: begin m_tag = "R5"; m_st = 0; end
        5: begin m_tag = "R7"; if (!bus_req) m_st = m_ret; end
        default: begin
          m_tag = (m_st == 6) ? "R9" : "R10";
          if (bus_req) begin m_ret = m_st; m_st = 5; end
          else if (|irq) m_st = 0;
        end
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk(m_tag, state_code, m_st);
    chk("R11", {bus_ack, rfsh_gnt, dma_ack, int_ack},
        {m_st == 5, m_st == 2,
         (m_st == 4) ? 2'(1 << m_ch) : 2'b00,
         (m_st == 3) ? 3'(1 << m_ln) : 3'b000});
  endtask

  task automatic idle();
    mc_end = 0; insn_end = 0; wait_req = 0; rfsh_req = 0; bus_req = 0;
    sleep_cmd = 0; stop_cmd = 0; dma_req = '0; irq = '0;
  endtask

  task automatic do_reset();
    idle(); rst = 1; tick(); tick(); rst = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset();
    chk("R1", {state_code, bus_ack, rfsh_gnt, dma_ack, int_ack}, 0);

    // R2: requests without machine-cycle end change nothing
    bus_req = 1; rfsh_req = 1; tick();
    chk("R2", state_code, 0);

    // R3: everything at once, bus request wins
    mc_end = 1; dma_req = 2'b11; irq = 3'b111; insn_end = 1; wait_req = 1; tick();
    chk("R3", state_code, 5);
    // R8: bus release ends with DMA pending -> run, then DMA ch0
    bus_req = 0; rfsh_req = 0; irq = 0; wait_req = 0; tick();
    chk("R8", state_code, 0);
    tick();
    chk("R8", {state_code, dma_ack}, {3'd4, 2'b01});

    // R4: interrupt held off until instruction end
    do_reset();
    mc_end = 1; irq = 3'b110; tick();
    chk("R4", state_code, 0);
    insn_end = 1; tick();
    chk("R4", {state_code, int_ack}, {3'd3, 3'b010});
    idle(); mc_end = 1; tick();
    chk("R5", state_code, 0);

    // R9: sleep ignores wait/refresh/DMA, bus release returns to sleep, irq wakes
    sleep_cmd = 1; tick(); sleep_cmd = 0;
    chk("R9", state_code, 6);
    wait_req = 1; rfsh_req = 1; dma_req = 2'b10; tick();
    chk("R9", state_code, 6);
    idle(); mc_end = 1; bus_req = 1; tick();
    chk("R9", {state_code, bus_ack}, {3'd5, 1'b1});
    bus_req = 0; tick();
    chk("R9", state_code, 6);
    irq = 3'b001; tick();
    chk("R9", state_code, 0);

    // R10: stop behaves the same way
    idle(); mc_end = 1; stop_cmd = 1; sleep_cmd = 1; tick(); stop_cmd = 0; sleep_cmd = 0;
    chk("R10", state_code, 7);
    rfsh_req = 1; dma_req = 2'b01; tick();
    chk("R10", state_code, 7);
    idle(); mc_end = 1; irq = 3'b100; tick();
    chk("R10", state_code, 0);

    // R6: wait holds while requested
    idle(); mc_end = 1; wait_req = 1; tick(); tick();
    chk("R6", state_code, 1);
    wait_req = 0; tick();
    chk("R6", state_code, 0);

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      mc_end    = ($urandom % 2) == 0;
      insn_end  = ($urandom % 3) == 0;
      wait_req  = ($urandom % 8) == 0;
      rfsh_req  = ($urandom % 10) == 0;
      bus_req   = ($urandom % 7) == 0;
      dma_req   = 2'(($urandom % 6 == 0) ? $urandom : 0);
      irq       = 3'(($urandom % 9 == 0) ? $urandom : 0);
      sleep_cmd = ($urandom % 15) == 0;
      stop_cmd  = ($urandom % 20) == 0;
      rst       = ($urandom % 500) == 0;
      tick();
    end
    rst = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule